// File: doc/BRIEF.md
# Programmable Linear-Feedback Shift Engine

This block is a software-composed linear-feedback shift engine for CRC generation, data scrambling and pseudo-random sequence work. A 40-bit residue register is shifted once per clock for a programmed number of steps. Five tap selectors each pick one residue bit. Per-source enable masks then build three bit streams from those taps and from the current data-in bit. The stream that enters the residue is called the feed bit. The second stream, when high, XORs a 40-bit polynomial into the residue. The third stream is the output bit, which is collected into a 16-bit data-out word.

Software sets up the engine through a byte-wide write port. It loads the residue, polynomial, compare value, shift count, gate masks, mode bits and tap selects, then writes the two data-in bytes. One of those byte writes starts the run. While the run is in progress the engine shows busy. One cycle after the run ends, it reports whether the final residue equals the compare value. A strobe from a neighbouring receiver can also load the data-in word directly when that feature is enabled.

Top module: `lfsr_engine`

## Requirements
- R1: While reset is held and after it is released, residue, data_out, data_in, busy and cmp_match are all 0.
- R2: A write to the data-in byte chosen by mode bit 2 starts a run (bit 2 set: address 24, the high byte; clear: address 23, the low byte). The other byte does not start a run. Busy rises on the cycle after the starting write. It stays high for exactly N+1 cycles, where N is the value in the shift-count register (address 15, bits 3:0), and one shift happens in each of those cycles.
- R3: Shift k of a run (k = 0..N) uses data-in bit 15-k when mode bit 3 is set, and data-in bit k when it is clear.
- R4: When mode bit 4 is set, the feed bit enters at residue bit 39 and the others move toward bit 0. When it is clear, the feed bit enters at bit 0 and the others move toward bit 39.
- R5: The feed bit is the XOR of the enabled terms: data-in bit (gate bit 4), tap1 (gate bit 5), tap2 (gate bit 6), tap3 (mode bit 0) and tap4 (mode bit 1). With no term enabled it is 0.
- R6: Tap selects live at addresses 18..21 (tap1..tap4) and 22 (output tap), 6 bits each. A value of 0..39 picks that residue bit. A value of 40 or more gives 0.
- R7: When gate bit 7 is set and the current data-in bit is 1, the shifted residue is XORed with the polynomial register (addresses 5..9, byte 0 at the lowest address).
- R8: On each shift, the output bit enters data_out at bit 15 and the other bits move one place down. The output bit is the XOR of the enabled terms: output tap (gate bit 0), data-in bit (gate bit 1), tap1 (gate bit 2) and tap2 (gate bit 3). After 16 shifts the first output bit sits at bit 0.
- R9: One cycle after the last shift, cmp_match is set to 1 if the residue equals the compare register (addresses 10..14) and to 0 otherwise. It holds that value until the next run ends.
- R10: Every register write arriving while busy is high is dropped. This includes writes to residue bytes (addresses 0..4), configuration and data-in.
- R11: When mode bit 5 is set and the engine is idle, al_strobe copies al_word into data_in without starting a run. When mode bit 5 is clear, the strobe is ignored. A same-cycle write to a data-in byte replaces that byte of the loaded word and still starts a run if it is the start byte.
- R12: The gate mask is at address 16 and the mode register at address 17. Residue and compare bytes are written least-significant byte first at ascending addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 8 | Register write byte |
| al_strobe | input | 1 | Receive-buffer-loaded strobe for autoload |
| al_word | input | 16 | Word copied on autoload |
| busy | output | 1 | Run in progress |
| cmp_match | output | 1 | Final residue equalled the compare value |
| residue | output | 40 | Residue register |
| data_in | output | 16 | Data-in register |
| data_out | output | 16 | Collected output stream |

## Verification
Two functions can land in the same cycle: an autoload strobe and a bus write to a data-in byte, including the byte that starts a run. The bench provokes this once as a directed case, with a distinct word on each side. It expects the written byte to win and the run to start. Random autoload strobes also fire throughout the randomized runs, including runs where they coincide with the starting write or arrive while busy. Each cycle is judged against the behavioural reference model in the bench, comparing data_in, busy and the residue that follows.

// File: rtl/lfsr_pkg.sv
`timescale 1ns/1ps
package lfsr_pkg;
  parameter int RES_W = 40;
  parameter int DIN_W = 16;
  parameter int CNT_W = 4;
  parameter int N_FB  = 4;
  parameter int ADDR_W = 5;

  localparam int SEL_W     = $clog2(RES_W);
  localparam int RES_BYTES = (RES_W + 7) / 8;
  localparam int RES_PAD   = RES_BYTES * 8;
  localparam int N_TAP     = N_FB + 1;

  localparam int A_RES    = 0;
  localparam int A_POLY   = A_RES + RES_BYTES;
  localparam int A_CMP    = A_POLY + RES_BYTES;
  localparam int A_CNT    = A_CMP + RES_BYTES;
  localparam int A_GATE   = A_CNT + 1;
  localparam int A_MODE   = A_GATE + 1;
  localparam int A_SEL    = A_MODE + 1;
  localparam int A_DIN_LO = A_SEL + N_TAP;
  localparam int A_DIN_HI = A_DIN_LO + 1;

  typedef struct packed {
    logic din_poly;
    logic fb2_feed;
    logic fb1_feed;
    logic din_feed;
    logic fb2_out;
    logic fb1_out;
    logic din_out;
    logic tap_out;
  } gate_t;

  typedef struct packed {
    logic autoload;
    logic lsb_exit;
    logic msb_first;
    logic trig_high;
    logic fb4_feed;
    logic fb3_feed;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  function automatic logic [RES_W-1:0] put_byte(input logic [RES_W-1:0] v,
                                                input int k,
                                                input logic [7:0] b);
    logic [RES_PAD-1:0] pad;
    pad = RES_PAD'(v);
    pad[8*k +: 8] = b;
    return pad[RES_W-1:0];
  endfunction
endpackage

// File: rtl/lfsr_tap_mux.sv
`timescale 1ns/1ps
module lfsr_tap_mux #(
  parameter int W  = 40,
  parameter int SW = 6
) (
  input  logic [W-1:0]  vec,
  input  logic [SW-1:0] sel,
  output logic          bit_o
);
  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (sel == SW'(i)) bit_o = vec[i];
    end
  end
endmodule

// File: rtl/lfsr_step.sv
`timescale 1ns/1ps
module lfsr_step
  import lfsr_pkg::*;
#(
  parameter int W = 40
) (
  input  logic [W-1:0] res,
  input  logic [W-1:0] poly,
  input  logic         din_bit,
  input  logic [3:0]   fb,
  input  logic         tap_bit,
  input  gate_t        gate,
  input  logic         lsb_exit,
  input  logic         fb3_en,
  input  logic         fb4_en,
  output logic [W-1:0] res_next,
  output logic         out_bit
);
  logic         feed;
  logic         px;
  logic [W-1:0] shifted;

  always_comb begin
    feed = (gate.din_feed & din_bit) ^ (gate.fb1_feed & fb[0]) ^
           (gate.fb2_feed & fb[1]) ^ (fb3_en & fb[2]) ^ (fb4_en & fb[3]);
    out_bit = (gate.tap_out & tap_bit) ^ (gate.din_out & din_bit) ^
              (gate.fb1_out & fb[0]) ^ (gate.fb2_out & fb[1]);
    px = gate.din_poly & din_bit;
    shifted = lsb_exit ? {feed, res[W-1:1]} : {res[W-2:0], feed};
    res_next = px ? (shifted ^ poly) : shifted;
  end
endmodule

// File: rtl/lfsr_engine.sv
`timescale 1ns/1ps
module lfsr_engine
  import lfsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              al_strobe,
  input  logic [DIN_W-1:0]  al_word,
  output logic              busy,
  output logic              cmp_match,
  output logic [RES_W-1:0]  residue,
  output logic [DIN_W-1:0]  data_in,
  output logic [DIN_W-1:0]  data_out
);
  logic rs_a, rs_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a <= 1'b0;
      rs_b <= 1'b0;
    end else begin
      rs_a <= 1'b1;
      rs_b <= rs_a;
    end
  end

  logic [RES_W-1:0] res_q, res_n, poly_q, poly_n, cmpv_q, cmpv_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, left_q, left_n, idx_q, idx_n;
  gate_t            gate_q, gate_n;
  mode_t            mode_q, mode_n;
  logic [SEL_W-1:0] sel_q [N_TAP];
  logic [SEL_W-1:0] sel_n [N_TAP];
  logic [DIN_W-1:0] din_q, din_n, dout_q, dout_n;
  logic             busy_q, busy_n, pend_q, pend_n, match_q, match_n;

  logic [N_TAP-1:0] tap_bits;
  logic             din_bit, out_bit, wr_ok, trig_hit;
  logic [RES_W-1:0] step_res;

  for (genvar t = 0; t < N_TAP; t++) begin : g_tap
    lfsr_tap_mux #(.W(RES_W), .SW(SEL_W)) u_mux (
      .vec(res_q), .sel(sel_q[t]), .bit_o(tap_bits[t])
    );
  end

  assign din_bit = mode_q.msb_first ? din_q[CNT_W'(DIN_W-1) - idx_q] : din_q[idx_q];

  lfsr_step #(.W(RES_W)) u_step (
    .res(res_q), .poly(poly_q), .din_bit(din_bit), .fb(tap_bits[3:0]),
    .tap_bit(tap_bits[N_TAP-1]), .gate(gate_q), .lsb_exit(mode_q.lsb_exit),
    .fb3_en(mode_q.fb3_feed), .fb4_en(mode_q.fb4_feed),
    .res_next(step_res), .out_bit(out_bit)
  );

  assign wr_ok    = wr_en & ~busy_q;
  assign trig_hit = wr_ok & (wr_addr == (mode_q.trig_high ? ADDR_W'(A_DIN_HI)
                                                          : ADDR_W'(A_DIN_LO)));

  always_comb begin
    res_n = res_q; poly_n = poly_q; cmpv_n = cmpv_q; cnt_n = cnt_q;
    gate_n = gate_q; mode_n = mode_q; din_n = din_q; dout_n = dout_q;
    left_n = left_q; idx_n = idx_q; busy_n = busy_q; pend_n = 1'b0;
    match_n = match_q;
    for (int t = 0; t < N_TAP; t++) sel_n[t] = sel_q[t];

    if (pend_q) match_n = (res_q == cmpv_q);

    if (busy_q) begin
      res_n  = step_res;
      dout_n = {out_bit, dout_q[DIN_W-1:1]};
      if (left_q == '0) begin
        busy_n = 1'b0;
        pend_n = 1'b1;
      end else begin
        left_n = left_q - 1'b1;
        idx_n  = idx_q + 1'b1;
      end
    end else begin
      if (al_strobe && mode_q.autoload) din_n = al_word;
      if (wr_ok) begin
        for (int k = 0; k < RES_BYTES; k++) begin
          if (wr_addr == ADDR_W'(A_RES + k))  res_n  = put_byte(res_q, k, wr_data);
          if (wr_addr == ADDR_W'(A_POLY + k)) poly_n = put_byte(poly_q, k, wr_data);
          if (wr_addr == ADDR_W'(A_CMP + k))  cmpv_n = put_byte(cmpv_q, k, wr_data);
        end
        for (int t = 0; t < N_TAP; t++) begin
          if (wr_addr == ADDR_W'(A_SEL + t)) sel_n[t] = wr_data[SEL_W-1:0];
        end
        if (wr_addr == ADDR_W'(A_CNT))    cnt_n  = wr_data[CNT_W-1:0];
        if (wr_addr == ADDR_W'(A_GATE))   gate_n = gate_t'(wr_data);
        if (wr_addr == ADDR_W'(A_MODE))   mode_n = mode_t'(wr_data[MODE_W-1:0]);
        if (wr_addr == ADDR_W'(A_DIN_LO)) din_n[7:0] = wr_data;
        if (wr_addr == ADDR_W'(A_DIN_HI)) din_n[DIN_W-1:8] = wr_data[DIN_W-9:0];
      end
      if (trig_hit) begin
        busy_n = 1'b1;
        left_n = cnt_q;
        idx_n  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rs_b) begin
    if (!rs_b) begin
      res_q <= '0; poly_q <= '0; cmpv_q <= '0; cnt_q <= '0;
      gate_q <= '0; mode_q <= '0; din_q <= '0; dout_q <= '0;
      left_q <= '0; idx_q <= '0; busy_q <= 1'b0; pend_q <= 1'b0;
      match_q <= 1'b0;
      for (int t = 0; t < N_TAP; t++) sel_q[t] <= '0;
    end else begin
      res_q <= res_n; poly_q <= poly_n; cmpv_q <= cmpv_n; cnt_q <= cnt_n;
      gate_q <= gate_n; mode_q <= mode_n; din_q <= din_n; dout_q <= dout_n;
      left_q <= left_n; idx_q <= idx_n; busy_q <= busy_n; pend_q <= pend_n;
      match_q <= match_n;
      for (int t = 0; t < N_TAP; t++) sel_q[t] <= sel_n[t];
    end
  end

  assign busy      = busy_q;
  assign cmp_match = match_q;
  assign residue   = res_q;
  assign data_in   = din_q;
  assign data_out  = dout_q;
endmodule

// File: rtl/lfsr_engine_chk.sv
`timescale 1ns/1ps
module lfsr_engine_chk
  import lfsr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              busy,
  input logic              cmp_match,
  input logic [RES_W-1:0]  residue,
  input logic [RES_W-1:0]  cmp_val,
  input logic [DIN_W-1:0]  data_in,
  input logic [DIN_W-1:0]  data_out
);
  localparam int MAXRUN = 2 ** CNT_W;
  logic [CNT_W+1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else        run_cnt <= busy ? run_cnt + 1'b1 : '0;
  end

  assert_start_from_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && (wr_addr == ADDR_W'(A_DIN_LO) ||
                                    wr_addr == ADDR_W'(A_DIN_HI))));

  assert_run_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt < (CNT_W+2)'(MAXRUN)));

  assert_dout_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> (data_out[DIN_W-2:0] == $past(data_out[DIN_W-1:1])));

  assert_compare_after_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> (cmp_match == $past(residue == cmp_val)));

  assert_din_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(data_in));
endmodule

bind lfsr_engine lfsr_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .busy(busy),
  .cmp_match(cmp_match), .residue(residue), .cmp_val(cmpv_q),
  .data_in(data_in), .data_out(data_out)
);

// File: tb/tb_lfsr_engine.sv
`timescale 1ns/1ps
module tb_lfsr_engine;
  import lfsr_pkg::*;

  logic              clk, rst_n, wr_en, al_strobe;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic [DIN_W-1:0]  al_word;
  logic              busy, cmp_match;
  logic [RES_W-1:0]  residue;
  logic [DIN_W-1:0]  data_in, data_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit rnd_al = 0;

  lfsr_engine dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .al_strobe(al_strobe), .al_word(al_word), .busy(busy), .cmp_match(cmp_match),
    .residue(residue), .data_in(data_in), .data_out(data_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  bit [39:0] m_res, m_poly, m_cmpv;
  bit [7:0]  m_gate;
  bit [5:0]  m_mode;
  bit [15:0] m_din, m_dout;
  bit        m_busy, m_pend, m_match;
  int        m_cnt, m_left, m_idx;
  int        m_sel [5];

  function automatic bit pick(input bit [39:0] v, input int s);
    return (s < 40) ? v[s] : 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_res = 0; m_poly = 0; m_cmpv = 0; m_gate = 0; m_mode = 0;
      m_din = 0; m_dout = 0; m_busy = 0; m_pend = 0; m_match = 0;
      m_cnt = 0; m_left = 0; m_idx = 0;
      for (int t = 0; t < 5; t++) m_sel[t] = 0;
    end else begin
      bit was_pend, dbit, feed, ob;
      bit [4:0] tv;
      int k, a;
      was_pend = m_pend;
      m_pend = 0;
      if (was_pend) m_match = (m_res == m_cmpv);
      if (m_busy) begin
        k = m_mode[3] ? 15 - m_idx : m_idx;
        dbit = m_din[k];
        for (int t = 0; t < 5; t++) tv[t] = pick(m_res, m_sel[t]);
        feed = (m_gate[4] & dbit) ^ (m_gate[5] & tv[0]) ^ (m_gate[6] & tv[1]) ^
               (m_mode[0] & tv[2]) ^ (m_mode[1] & tv[3]);
        ob = (m_gate[0] & tv[4]) ^ (m_gate[1] & dbit) ^ (m_gate[2] & tv[0]) ^
             (m_gate[3] & tv[1]);
        if (m_mode[4]) m_res = {feed, m_res[39:1]};
        else           m_res = {m_res[38:0], feed};
        if (m_gate[7] && dbit) m_res = m_res ^ m_poly;
        m_dout = {ob, m_dout[15:1]};
        if (m_left == 0) begin m_busy = 0; m_pend = 1; end
        else begin m_left--; m_idx++; end
      end else begin
        if (al_strobe && m_mode[5]) m_din = al_word;
        if (wr_en) begin
          a = int'(wr_addr);
          if (a < 5)                 m_res[8*a +: 8]       = wr_data;
          else if (a < 10)           m_poly[8*(a-5) +: 8]  = wr_data;
          else if (a < 15)           m_cmpv[8*(a-10) +: 8] = wr_data;
          else if (a == 15)          m_cnt = int'(wr_data[3:0]);
          else if (a == 16)          m_gate = wr_data;
          else if (a == 17)          m_mode = wr_data[5:0];
          else if (a >= 18 && a < 23) m_sel[a-18] = int'(wr_data[5:0]);
          else if (a == 23)          m_din[7:0] = wr_data;
          else if (a == 24)          m_din[15:8] = wr_data;
          if (a == (m_mode[2] ? 24 : 23)) begin
            m_busy = 1; m_left = m_cnt; m_idx = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(busy, m_busy, "R2 busy vs model");
      chk(residue, m_res, "R5 residue vs model");
      chk(data_out, m_dout, "R8 data_out vs model");
      chk(cmp_match, m_match, "R9 cmp_match vs model");
      chk(data_in, m_din, "R11 data_in vs model");
    end
  end

  task automatic drive_idle();
    wr_en = 1'b0;
    al_strobe = rnd_al ? ($urandom % 4 == 0) : 1'b0;
    al_word = 16'($urandom);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    drive_idle();
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
  endtask

  task automatic set40(input int base, input logic [39:0] v);
    for (int k = 0; k < 5; k++) wr(base + k, v[8*k +: 8]);
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(negedge clk); drive_idle();
      if (busy) n++;
    end while (busy);
    @(negedge clk); drive_idle();
  endtask

  task automatic setup(input logic [39:0] r, input logic [7:0] g, input logic [5:0] m,
                       input int cnt);
    set40(A_RES, r); wr(A_GATE, g); wr(A_MODE, {2'b00, m}); wr(A_CNT, 8'(cnt));
  endtask

  initial begin
    int n;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    al_strobe = 1'b0; al_word = '0;
    repeat (3) @(negedge clk);
    chk(residue, 0, "R1 reset residue");
    chk(data_out, 0, "R1 reset data_out");
    chk({busy, cmp_match}, 0, "R1 reset flags");
    chk(data_in, 0, "R1 reset data_in");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, cmp_match, data_in}, 0, "R1 after release");

    // R3/R12 LSB-first, left shift, feed from data-in; compare set to 0x18 for R9
    setup(40'h1, 8'h10, 6'h00, 3);
    set40(A_CMP, 40'h18);
    wr(A_DIN_HI, 8'h00);
    @(negedge clk); drive_idle();
    chk(busy, 0, "R2 non-start byte leaves idle");
    wr(A_DIN_LO, 8'h01);
    wait_done(n);
    chk(n, 4, "R2 busy length N+1");
    chk(residue, 40'h18, "R3 lsb-first residue");
    chk(cmp_match, 1, "R9 match set");

    // R3 MSB-first
    setup(40'h1, 8'h10, 6'h08, 3);
    wr(A_DIN_HI, 8'h80); wr(A_DIN_LO, 8'h00);
    wait_done(n);
    chk(residue, 40'h18, "R3 msb-first residue");

    // R4 direction: feed enters at bit 39; compare 0x18 now mismatches
    setup(40'h80_0000_0000, 8'h10, 6'h10, 0);
    wr(A_DIN_HI, 8'h00); wr(A_DIN_LO, 8'h01);
    wait_done(n);
    chk(residue, 40'hC0_0000_0000, "R4 lsb-exit shift");
    chk(cmp_match, 0, "R9 match cleared");

    // R7 polynomial xor
    setup(40'h0, 8'h80, 6'h00, 1);
    set40(A_POLY, 40'hFF);
    wr(A_DIN_HI, 8'hFF); wr(A_DIN_LO, 8'hFF);
    wait_done(n);
    chk(residue, 40'h101, "R7 poly xor");

    // R6 / R5 tap selects
    setup(40'h1, 8'h20, 6'h00, 0);
    wr(A_SEL, 8'd63); wr(A_DIN_LO, 8'h00);
    wait_done(n);
    chk(residue, 40'h2, "R6 out-of-range tap gives 0");
    setup(40'h1, 8'h20, 6'h00, 0);
    wr(A_SEL, 8'd0); wr(A_DIN_LO, 8'h00);
    wait_done(n);
    chk(residue, 40'h3, "R5 tap1 feeds residue");

    // R8 data-out collection over 16 shifts
    setup(40'h0, 8'h02, 6'h00, 15);
    wr(A_DIN_HI, 8'hA5); wr(A_DIN_LO, 8'hC3);
    @(negedge clk); drive_idle();
    wr(A_DIN_HI, 8'h00); wr(A_RES, 8'hEE); wr(A_MODE, 8'h3F);
    wait_done(n);
    chk(data_out, 16'hA5C3, "R8 data_out word");
    chk(data_in, 16'hA5C3, "R10 data_in unchanged by busy write");
    chk(residue, 40'h0, "R10 residue write dropped");

    // R11 autoload disabled, enabled, and concurrent with start write
    @(negedge clk); drive_idle();
    al_strobe = 1'b1; al_word = 16'h1234;
    @(negedge clk); drive_idle();
    chk(data_in, 16'hA5C3, "R11 strobe ignored when disabled");
    wr(A_MODE, 8'h20);
    @(negedge clk); drive_idle();
    al_strobe = 1'b1; al_word = 16'h5A5A;
    @(negedge clk); drive_idle();
    chk(data_in, 16'h5A5A, "R11 autoload copies word");
    chk(busy, 0, "R11 autoload does not start");
    wr(A_DIN_LO, 8'h12);
    al_strobe = 1'b1; al_word = 16'hABCD;
    @(negedge clk); drive_idle();
    chk(data_in, 16'hAB12, "R11 bus byte wins over autoload");
    chk(busy, 1, "R11 concurrent start write runs");
    wait_done(n);

    // Randomized runs
    for (int op = 0; op < 80; op++) begin
      logic [63:0] r1, r2, r3;
      logic [7:0]  mv;
      rnd_al = (op % 3 == 0);
      r1 = {$urandom, $urandom}; r2 = {$urandom, $urandom}; r3 = {$urandom, $urandom};
      set40(A_RES, r1[39:0]); set40(A_POLY, r2[39:0]); set40(A_CMP, r3[39:0]);
      mv = 8'($urandom % 64);
      wr(A_CNT, 8'($urandom % 16)); wr(A_GATE, 8'($urandom)); wr(A_MODE, mv);
      for (int t = 0; t < 5; t++) wr(A_SEL + t, 8'($urandom % 48));
      if (mv[2]) begin wr(A_DIN_LO, 8'($urandom)); wr(A_DIN_HI, 8'($urandom)); end
      else       begin wr(A_DIN_HI, 8'($urandom)); wr(A_DIN_LO, 8'($urandom)); end
      wr(int'($urandom % 25), 8'($urandom));
      wait_done(n);
      wait_done(n);
    end
    rnd_al = 0;
    repeat (3) @(negedge clk);
    drive_idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule